// File: doc/BRIEF.md
# Page Table Level Probe

This block is a diagnostic lookup engine for a three-level page table held in memory. Given a virtual address and a requested stop level, it reads the context entry and then up to three table entries. It returns the raw 32-bit entry found where it stopped. If the walk cannot legally reach that point, it returns zero. It never writes memory, never changes an entry and never raises a fault. Every failure is reported as a zero result.

A caller loads the virtual address, the stop level, the context table pointer and the context number, and pulses `start`. The engine captures these inputs and becomes busy. It issues one 32-bit read at a time on a valid/ready request channel and takes each word from a valid/ready response channel. When the walk ends it pulses `done` for one cycle and presents `result`, which holds until the next completion.

On the request channel, `rd_req_valid` stays high and `rd_req_addr` stays fixed until the memory raises `rd_req_ready`, so the memory may stall the engine for as long as it likes. On the response channel, `rd_rsp_ready` is high only while a read is outstanding, and the word is taken in the cycle where `rd_rsp_valid` meets it. At most one read is outstanding at any time.

Top module: `pt_probe_engine`

## Requirements
- R1: With stop level 3, a context entry of type 1 (table descriptor) is returned unchanged. The entry type is bits 1:0: 0 invalid, 1 descriptor, 2 page, 3 reserved.
- R2: A context entry of type 0, 2 or 3 gives a result of 0 after a single read, whatever the stop level.
- R3: A type 2 (page) entry at the first or second table level is returned at once, whatever the stop level, and no further read is issued.
- R4: A type 0 or type 3 entry at any table level gives a result of 0, and the walk ends there.
- R5: At the third table level, only a type 2 entry is returned; a type 1 entry there gives 0. A stop level of 0 never returns a descriptor.
- R6: The first read goes to (pointer << 4) + (context number << 4). Each later read goes to ((entry & ~3) << 4) + 4 × index. The index is virtual address bits 31:24 for the first table level, 23:18 for the second and 17:12 for the third.
- R7: While `rd_req_valid` is high and `rd_req_ready` is low, the request stays valid and its address does not change.
- R8: Only one read is outstanding at a time. `rd_rsp_ready` is high only while a read awaits its word. The number of reads equals the number of entries the walk visits.
- R9: `done` is a one-cycle pulse in the cycle after the final response is accepted. `result` keeps its value until the next pulse.
- R10: A `start` pulse while busy is ignored. Address, level and context inputs are captured when the probe starts, and later changes to them do not affect the probe.
- R11: After reset, `busy`, `done` and `rd_req_valid` are low and `result` is 0.
- R12: With stop level 2 a type 1 entry at the first table level is returned, and with stop level 1 a type 1 entry at the second table level is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a probe (taken only when idle) |
| level | input | 2 | Stop level: 3 context, 2 first, 1 second, 0 full walk |
| vaddr | input | 32 | Virtual address to look up |
| ctx_ptr | input | 32 | Context table pointer |
| ctx_num | input | CTX_W | Context number |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Entry found, or 0 |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts request |
| rd_req_addr | output | PA_W | Physical byte address of the read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Engine accepts read data |
| rd_rsp_data | input | 32 | Read data word |

## Verification
A wrong walk stage or a corrupted captured level shows up at the very next request as a wrong `rd_req_addr`. It can also show up as an extra or missing read, or as `done` arriving one read early or late. The bench records every request address and compares the sequence and count against a reference walk. A wrong decision on the returned word shows at `result` in the cycle `done` pulses, one cycle after the response handshake. Random tables with mixed entry types and random stalls on both channels reach all outcomes, and directed chains pin each stop level.

// File: rtl/ptw_probe_pkg.sv
`timescale 1ns/1ps
package ptw_probe_pkg;

  localparam int ENTRY_W   = 32;
  localparam int TYPE_W    = 2;
  localparam int PTR_SHIFT = 4;
  localparam int LEVELS    = 3;

  // walk position: context entry, then three table levels
  typedef enum logic [1:0] {
    ST_CTX = 2'd0,
    ST_L1  = 2'd1,
    ST_L2  = 2'd2,
    ST_L3  = 2'd3
  } walk_stage_e;

  typedef enum logic [TYPE_W-1:0] {
    ET_INVALID = 2'd0,
    ET_TABLE   = 2'd1,
    ET_PAGE    = 2'd2,
    ET_RSVD    = 2'd3
  } entry_type_e;

  typedef enum logic [1:0] {
    ACT_FAIL    = 2'd0,
    ACT_HIT     = 2'd1,
    ACT_DESCEND = 2'd2
  } probe_act_e;

endpackage

// File: rtl/probe_addr_gen.sv
`timescale 1ns/1ps
module probe_addr_gen
  import ptw_probe_pkg::*;
#(
  parameter int PA_W  = 36,
  parameter int CTX_W = 16
) (
  input  walk_stage_e          stage,
  input  logic [ENTRY_W-1:0]   entry,
  input  logic [31:0]          vaddr,
  input  logic [31:0]          ctx_ptr,
  input  logic [CTX_W-1:0]     ctx_num,
  output logic [PA_W-1:0]      addr
);

  logic [PA_W-1:0] ctx_addr;
  logic [PA_W-1:0] tbl_base;
  logic [PA_W-1:0] lvl_off [LEVELS+1];

  assign ctx_addr = (PA_W'(ctx_ptr) << PTR_SHIFT) + (PA_W'(ctx_num) << PTR_SHIFT);
  assign tbl_base = PA_W'({entry[ENTRY_W-1:TYPE_W], {TYPE_W{1'b0}}}) << PTR_SHIFT;
  assign lvl_off[0] = '0;

  // one index slice per table level: 31:24, 23:18, 17:12
  for (genvar s = 1; s <= LEVELS; s++) begin : g_idx
    localparam int LO = 30 - 6 * s;
    localparam int HI = (s == 1) ? 31 : LO + 5;
    assign lvl_off[s] = PA_W'(vaddr[HI:LO]) << 2;
  end

  always_comb begin
    if (stage == ST_CTX) addr = ctx_addr;
    else                 addr = tbl_base + lvl_off[stage];
  end

  logic unused_bits;
  assign unused_bits = ^{vaddr[11:0], entry[TYPE_W-1:0]};

endmodule

// File: rtl/probe_entry_judge.sv
`timescale 1ns/1ps
module probe_entry_judge
  import ptw_probe_pkg::*;
(
  input  walk_stage_e        stage,
  input  logic [1:0]         level,
  input  logic [ENTRY_W-1:0] entry,
  output probe_act_e         act
);

  entry_type_e etype;
  logic [1:0]  stop_here;

  assign etype     = entry_type_e'(entry[TYPE_W-1:0]);
  assign stop_here = 2'd3 - 2'(stage);

  always_comb begin
    act = ACT_FAIL;
    unique case (etype)
      ET_TABLE: begin
        if (stage == ST_L3)          act = ACT_FAIL;
        else if (level == stop_here) act = ACT_HIT;
        else                         act = ACT_DESCEND;
      end
      ET_PAGE: begin
        if (stage == ST_CTX) act = ACT_FAIL;
        else                 act = ACT_HIT;
      end
      default: act = ACT_FAIL;
    endcase
  end

  logic [ENTRY_W-1:0] unused_entry;
  assign unused_entry = entry;

endmodule

// File: rtl/pt_probe_engine.sv
`timescale 1ns/1ps
module pt_probe_engine
  import ptw_probe_pkg::*;
#(
  parameter int PA_W  = 36,
  parameter int CTX_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         level,
  input  logic [31:0]        vaddr,
  input  logic [31:0]        ctx_ptr,
  input  logic [CTX_W-1:0]   ctx_num,
  output logic               busy,
  output logic               done,
  output logic [ENTRY_W-1:0] result,
  output logic               rd_req_valid,
  input  logic               rd_req_ready,
  output logic [PA_W-1:0]    rd_req_addr,
  input  logic               rd_rsp_valid,
  output logic               rd_rsp_ready,
  input  logic [ENTRY_W-1:0] rd_rsp_data
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_AWAIT} fsm_e;

  fsm_e               state_q;
  walk_stage_e        stage_q;
  walk_stage_e        stage_nx;
  logic [1:0]         lvl_q;
  logic [31:0]        va_q;
  logic [PA_W-1:0]    addr_q;
  logic [PA_W-1:0]    addr_calc;
  logic [ENTRY_W-1:0] result_q;
  logic               done_q;
  logic               idle;
  probe_act_e         act;

  assign idle     = (state_q == S_IDLE);
  assign stage_nx = idle ? ST_CTX : walk_stage_e'(stage_q + 2'd1);

  probe_addr_gen #(.PA_W(PA_W), .CTX_W(CTX_W)) u_addr (
    .stage   (stage_nx),
    .entry   (rd_rsp_data),
    .vaddr   (idle ? vaddr : va_q),
    .ctx_ptr (ctx_ptr),
    .ctx_num (ctx_num),
    .addr    (addr_calc)
  );

  probe_entry_judge u_judge (
    .stage (stage_q),
    .level (lvl_q),
    .entry (rd_rsp_data),
    .act   (act)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      stage_q  <= ST_CTX;
      lvl_q    <= '0;
      va_q     <= '0;
      addr_q   <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start) begin
            va_q    <= vaddr;
            lvl_q   <= level;
            stage_q <= ST_CTX;
            addr_q  <= addr_calc;
            state_q <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (rd_req_ready) state_q <= S_AWAIT;
        end
        S_AWAIT: begin
          if (rd_rsp_valid) begin
            unique case (act)
              ACT_DESCEND: begin
                stage_q <= stage_nx;
                addr_q  <= addr_calc;
                state_q <= S_ISSUE;
              end
              ACT_HIT: begin
                result_q <= rd_rsp_data;
                done_q   <= 1'b1;
                state_q  <= S_IDLE;
              end
              default: begin
                result_q <= '0;
                done_q   <= 1'b1;
                state_q  <= S_IDLE;
              end
            endcase
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy         = !idle;
  assign done         = done_q;
  assign result       = result_q;
  assign rd_req_valid = (state_q == S_ISSUE);
  assign rd_req_addr  = addr_q;
  assign rd_rsp_ready = (state_q == S_AWAIT);

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  assert_one_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && rd_rsp_ready));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  assert_result_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && (result != '0) |-> (result[1:0] == 2'd1) || (result[1:0] == 2'd2));

  assert_no_final_table_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && (result[1:0] == 2'd1) |-> lvl_q != 2'd0);

endmodule

// File: tb/pt_probe_engine_bench.sv
`timescale 1ns/1ps
module pt_probe_engine_bench;
  localparam int PA_W = 36, CTX_W = 16, MEM_WORDS = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic start = 0; logic [1:0] level = 0; logic [31:0] vaddr = 0, ctx_ptr = 0;
  logic [CTX_W-1:0] ctx_num = 0;
  logic busy, done, rd_req_valid, rd_rsp_ready;
  logic [31:0] result, rd_rsp_data;
  logic rd_req_ready, rd_rsp_valid;
  logic [PA_W-1:0] rd_req_addr;

  pt_probe_engine #(.PA_W(PA_W), .CTX_W(CTX_W)) u_pt_probe_engine (
    .clk, .rst_n, .start, .level, .vaddr, .ctx_ptr, .ctx_num, .busy, .done, .result,
    .rd_req_valid, .rd_req_ready, .rd_req_addr, .rd_rsp_valid, .rd_rsp_ready, .rd_rsp_data);

  logic [31:0] mem [MEM_WORDS];
  logic [PA_W-1:0] act_addr [8];
  logic [PA_W-1:0] exp_addr [4];
  int act_n = 0, exp_n = 0, oob = 0, tests = 0, fails = 0;
  string exp_tag;

  function automatic logic [31:0] mem_rd(logic [PA_W-1:0] a);
    if (a >= PA_W'(MEM_WORDS * 4)) return 32'hBAD0_0003;
    return mem[a[13:2]];
  endfunction

  // reference walk from the requirements
  function automatic logic [31:0] ref_probe(logic [31:0] va, logic [1:0] lvl,
                                            logic [31:0] ptr, logic [CTX_W-1:0] num);
    logic [PA_W-1:0] a; logic [31:0] e; logic [7:0] idx;
    exp_n = 0;
    a = (PA_W'(ptr) << 4) + (PA_W'(num) << 4);
    for (int s = 0; s < 4; s++) begin
      exp_addr[exp_n] = a; exp_n++;
      e = mem_rd(a);
      if (s == 0) begin
        if (e[1:0] != 2'd1) begin exp_tag = "R2"; return 0; end
        if (lvl == 2'd3) begin exp_tag = "R1"; return e; end
      end else begin
        if (e[1:0] == 2'd0 || e[1:0] == 2'd3) begin exp_tag = "R4"; return 0; end
        if (e[1:0] == 2'd2) begin exp_tag = (s == 3) ? "R5" : "R3"; return e; end
        if (s == 3) begin exp_tag = "R5"; return 0; end
        if (int'(lvl) == 3 - s) begin exp_tag = "R12"; return e; end
      end
      idx = (s == 0) ? va[31:24] : (s == 1) ? {2'b0, va[23:18]} : {2'b0, va[17:12]};
      a = (PA_W'({e[31:2], 2'b00}) << 4) + PA_W'(idx) * 4;
    end
    exp_tag = "R6";
    return 0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: random stalls on requests, random response latency
  initial begin
    bit pend; int lat; logic [PA_W-1:0] pa;
    pend = 0; lat = 0; pa = '0;
    rd_req_ready = 0; rd_rsp_valid = 0; rd_rsp_data = 0;
    forever begin
      @(posedge clk);
      if (rd_rsp_valid && rd_rsp_ready) begin rd_rsp_valid <= 1'b0; pend = 0; end
      if (rd_req_valid && rd_req_ready) begin
        if (act_n < 8) act_addr[act_n] = rd_req_addr;
        act_n++;
        if (rd_req_addr >= PA_W'(MEM_WORDS * 4)) oob++;
        pend = 1; lat = $urandom % 3; pa = rd_req_addr;
      end else if (pend && !rd_rsp_valid) begin
        if (lat == 0) begin rd_rsp_valid <= 1'b1; rd_rsp_data <= mem_rd(pa); end
        else lat--;
      end
      rd_req_ready <= ($urandom % 3) != 0;
    end
  end

  task automatic probe(input logic [31:0] va, input logic [1:0] lvl, input logic [31:0] ptr,
                       input logic [CTX_W-1:0] num, input bit poke, output logic [31:0] got);
    logic [31:0] expv; string tag; int n;
    expv = ref_probe(va, lvl, ptr, num);
    tag = poke ? "R10" : exp_tag;
    @(negedge clk);
    act_n = 0; vaddr = va; level = lvl; ctx_ptr = ptr; ctx_num = num; start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      vaddr = ~va; level = ~lvl; ctx_ptr = ptr ^ 32'h0000_01F0; start = 1;
      @(negedge clk);
      start = 0;
    end
    n = 0;
    while (!done && n < 300) begin @(negedge clk); n++; end
    got = result;
    check(done === 1'b1, "R9", 64'(done), 64'd1);
    check(result === expv, tag, 64'(result), 64'(expv));
    check(act_n == exp_n, "R8", 64'(act_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < act_n; i++)
      check(act_addr[i] === exp_addr[i], "R6", 64'(act_addr[i]), 64'(exp_addr[i]));
    @(negedge clk);
    check(done === 1'b0, "R9", 64'(done), 64'd0);
    check(result === expv, "R9", 64'(result), 64'(expv));
  endtask

  task automatic fill_random();
    logic [31:0] r;
    for (int i = 0; i < MEM_WORDS; i++) begin
      r = $urandom;
      case (r % 8)
        0:       mem[i] = {r[31:2], 2'd0};
        1,2,3,4: mem[i] = ((((r >> 8) % 240)) << 2) | 32'd1;
        5,6:     mem[i] = {$urandom} & 32'hFFFF_FFFC | 32'd2;
        default: mem[i] = {r[31:2], 2'd3};
      endcase
    end
  endtask

  task automatic set_chain();
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'd0;
    mem[12'h048] = 32'h0000_0101;
    mem[12'h4A5] = 32'h0000_0141;
    mem[12'h530] = 32'h0000_0181;
    mem[12'h637] = 32'hDEAD_B00E;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] got;
    localparam logic [31:0] VA = 32'hA5C3_7000;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(busy === 0 && done === 0 && rd_req_valid === 0, "R11", {busy, done, rd_req_valid}, 0);
    check(result === 0, "R11", 64'(result), 0);
    rst_n = 1;
    @(negedge clk);
    check(busy === 0 && rd_req_valid === 0 && result === 0, "R11", 64'(result), 0);

    set_chain();
    probe(VA, 2'd3, 32'h10, 16'h2, 0, got); check(got == 32'h101, "R1", got, 32'h101);
    probe(VA, 2'd2, 32'h10, 16'h2, 0, got); check(got == 32'h141, "R12", got, 32'h141);
    probe(VA, 2'd1, 32'h10, 16'h2, 0, got); check(got == 32'h181, "R12", got, 32'h181);
    probe(VA, 2'd0, 32'h10, 16'h2, 0, got); check(got == 32'hDEADB00E, "R6", got, 32'hDEADB00E);
    probe(VA, 2'd0, 32'h10, 16'h2, 1, got); check(got == 32'hDEADB00E, "R10", got, 32'hDEADB00E);
    mem[12'h637] = 32'h0000_0181;
    probe(VA, 2'd0, 32'h10, 16'h2, 0, got); check(got == 0, "R5", got, 0);
    mem[12'h530] = 32'h1234_5672;
    probe(VA, 2'd0, 32'h10, 16'h2, 0, got); check(got == 32'h12345672, "R3", got, 32'h12345672);
    probe(VA, 2'd1, 32'h10, 16'h2, 0, got); check(got == 32'h12345672, "R3", got, 32'h12345672);
    mem[12'h4A5] = 32'h0000_00A3;
    probe(VA, 2'd0, 32'h10, 16'h2, 0, got); check(got == 0, "R4", got, 0);
    mem[12'h4A5] = 32'h0000_0000;
    probe(VA, 2'd1, 32'h10, 16'h2, 0, got); check(got == 0, "R4", got, 0);
    mem[12'h048] = 32'h0000_0102;
    probe(VA, 2'd3, 32'h10, 16'h2, 0, got); check(got == 0, "R2", got, 0);
    mem[12'h048] = 32'h0000_0103;
    probe(VA, 2'd0, 32'h10, 16'h2, 0, got); check(got == 0, "R2", got, 0);

    for (int blk = 0; blk < 6; blk++) begin
      fill_random();
      for (int k = 0; k < 50; k++) begin
        probe($urandom, 2'($urandom % 4), $urandom % 512, CTX_W'($urandom % 512), (k % 9) == 4, got);
      end
    end

    check(oob == 0, "R6", 64'(oob), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule